// File: doc/BRIEF.md
# Multi-Source Reset Controller with Start-Up Timers

The block gathers seven reset requests and turns them into one internal reset. The requests are power-on, brown-out, the external reset pin, watchdog time-out, configuration mismatch, a software reset instruction, and a stack full or underflow event. Any accepted request sets a set/reset hold, and the internal reset stays asserted for as long as that hold is set. The hold is cleared only after a start-up sequence finishes. That sequence is a power-up timer, counted in ticks of a slow internal timebase, followed by an oscillator start-up timer, counted in cycles of the oscillator clock. A request that arrives while the sequence is running restarts it from the beginning.

The power-up timer runs only when power-on or brown-out took part in the reset. Either timer can be bypassed by a configuration input. A sticky cause register records which requests occurred. Software can overwrite this register through a write port to re-arm the flags, and such a write never causes a reset. Supply-level detection lies outside the block: power-on and brown-out arrive as synchronous digital strobes. All logic is clocked by the oscillator clock, and the slow timebase arrives as a one-cycle enable strobe.

Top module: `rst_ctrl`

## Requirements
- R1: Each cause (power-on, brown-out, pin, watchdog, configuration mismatch, software, stack) held high at a clock edge, with its enable set where one exists, makes `sys_rst` 1 after that edge.
- R2: `pin_req` has no effect while `pin_en` is 0: `sys_rst` stays 0 and `cause_flags` is unchanged.
- R3: `bor_req` has no effect while `bor_en` is 0: `sys_rst` stays 0 and `cause_flags` is unchanged.
- R4: When power-on or brown-out took part in the reset and `skip_pwrt` is 0, the power-up timer runs first. Counting clock edges from the first edge with no request (edge 1), the timer expires at the edge of the PW_TICKS-th `tb_tick` strobe. Other causes never run it.
- R5: The oscillator start-up timer starts when the power-up timer expires, or at edge 1 if the power-up timer does not run. It expires at its OST_CYC-th edge, and `sys_rst` falls at that edge.
- R6: With `skip_ost` = 1, `sys_rst` falls at the edge where the power-up timer expires. If the power-up timer does not run either, it falls at edge 1.
- R7: A request accepted during the timer sequence keeps `sys_rst` at 1, clears both counters, and restarts timing from its own release.
- R8: Power-on sets `cause_flags` to 7'b0000001. The bit map is: 0 power-on, 1 brown-out, 2 pin, 3 watchdog, 4 configuration mismatch, 5 software, 6 stack.
- R9: Any other accepted cause sets only its own bit of `cause_flags` and leaves the other bits unchanged.
- R10: A write (`flag_we` = 1) loads `flag_wdata` into `cause_flags` after the edge and never asserts `sys_rst`.
- R11: A cause bit set by an event in the same cycle as a write stays 1; the event wins over the written 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_req | input | 1 | Power-on request; also initialises the block |
| bor_req | input | 1 | Brown-out request |
| bor_en | input | 1 | Brown-out reset enable |
| pin_req | input | 1 | External reset pin request |
| pin_en | input | 1 | External pin reset enable |
| wdt_req | input | 1 | Watchdog time-out request |
| cfg_req | input | 1 | Configuration mismatch request |
| swr_req | input | 1 | Software reset instruction |
| stk_req | input | 1 | Stack full/underflow request |
| tb_tick | input | 1 | One-cycle strobe of the slow internal timebase |
| skip_pwrt | input | 1 | Bypass the power-up timer |
| skip_ost | input | 1 | Bypass the oscillator start-up timer |
| flag_we | input | 1 | Cause register write strobe |
| flag_wdata | input | 7 | Cause register write data |
| sys_rst | output | 1 | Internal reset, active high |
| cause_flags | output | 7 | Sticky reset cause flags |

## Verification
The bench builds the block with PW_TICKS = 4 and OST_CYC = 8, and drives the timebase strobe every third cycle. This makes a full release sequence last at most 20 cycles. With sequences that short, the bench can sweep all seven causes across all four bypass combinations. For every run it checks the release cycle against an arithmetic formula, and it checks that the cause flags match a pattern it wrote beforehand. The short timers also bring within reach the gated enables, a restart in the middle of the oscillator timer, and an event that collides with a software write in the same cycle.

// File: rtl/rst_ctrl.sv
module rst_ctrl #(
  parameter int PW_TICKS = 64,
  parameter int OST_CYC  = 1024
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       bor_req,
  input  logic       bor_en,
  input  logic       pin_req,
  input  logic       pin_en,
  input  logic       wdt_req,
  input  logic       cfg_req,
  input  logic       swr_req,
  input  logic       stk_req,
  input  logic       tb_tick,
  input  logic       skip_pwrt,
  input  logic       skip_ost,
  input  logic       flag_we,
  input  logic [6:0] flag_wdata,
  output logic       sys_rst,
  output logic [6:0] cause_flags
);
  localparam int PW_W  = $clog2(PW_TICKS + 1);
  localparam int OST_W = $clog2(OST_CYC + 1);

  typedef enum logic [1:0] {PH_PWR, PH_OST, PH_REL} phase_t;

  phase_t           phase;
  logic             hold, pw_need;
  logic [PW_W-1:0]  pw_cnt;
  logic [OST_W-1:0] ost_cnt;
  logic [6:0]       ev;

  assign ev = {stk_req, swr_req, cfg_req, wdt_req, pin_req & pin_en,
               bor_req & bor_en, por_req};

  wire    pwr_req  = ev[0] | ev[1];
  wire    any_req  = |ev;
  wire    pw_use   = (pw_need | pwr_req) & ~skip_pwrt;
  phase_t start_ph;
  assign  start_ph = pw_use ? PH_PWR : (skip_ost ? PH_REL : PH_OST);
  wire    pw_last  = tb_tick && (pw_cnt == PW_W'(PW_TICKS - 1));
  wire    ost_last = (ost_cnt == OST_W'(OST_CYC - 1));

  assign sys_rst = hold;

  always_ff @(posedge clk) begin
    if (any_req) begin
      hold    <= 1'b1;
      phase   <= start_ph;
      pw_cnt  <= '0;
      ost_cnt <= '0;
      pw_need <= pw_need | pwr_req;
    end else begin
      case (phase)
        PH_PWR: if (tb_tick) begin
          pw_cnt <= pw_cnt + 1'b1;
          if (pw_last) begin
            if (skip_ost) begin
              phase   <= PH_REL;
              hold    <= 1'b0;
              pw_need <= 1'b0;
            end else begin
              phase <= PH_OST;
            end
          end
        end
        PH_OST: begin
          ost_cnt <= ost_cnt + 1'b1;
          if (ost_last) begin
            phase   <= PH_REL;
            hold    <= 1'b0;
            pw_need <= 1'b0;
          end
        end
        default: begin
          hold    <= 1'b0;
          pw_need <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por_req) cause_flags <= 7'b0000001;
    else         cause_flags <= (flag_we ? flag_wdata : cause_flags) | ev;
  end
endmodule

module rst_ctrl_chk (
  input logic       clk,
  input logic       por_req,
  input logic       bor_req,
  input logic       bor_en,
  input logic       pin_req,
  input logic       pin_en,
  input logic       wdt_req,
  input logic       cfg_req,
  input logic       swr_req,
  input logic       stk_req,
  input logic       flag_we,
  input logic [6:0] flag_wdata,
  input logic       sys_rst,
  input logic [6:0] cause_flags
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (por_req) armed <= 1'b1;

  wire other = wdt_req | cfg_req | swr_req | stk_req;
  wire acc   = por_req | (bor_req & bor_en) | (pin_req & pin_en) | other;

  AST_REQ_ASSERTS: assert property (@(posedge clk) disable iff (!armed)
    acc |=> sys_rst); // R1
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!armed || por_req)
    (pin_req && !pin_en && !acc && !sys_rst && !flag_we) |=> (!sys_rst && $stable(cause_flags))); // R2
  AST_BOR_GATED: assert property (@(posedge clk) disable iff (!armed || por_req)
    (bor_req && !bor_en && !acc && !sys_rst && !flag_we) |=> (!sys_rst && $stable(cause_flags))); // R3
  AST_QUIET_RELEASE: assert property (@(posedge clk) disable iff (!armed)
    $fell(sys_rst) |-> !$past(acc)); // R7
  AST_POR_DEFAULTS: assert property (@(posedge clk) disable iff (!armed)
    por_req |=> (cause_flags == 7'b0000001)); // R8
  AST_WDT_ONLY_OWN: assert property (@(posedge clk) disable iff (!armed || por_req)
    (wdt_req && !flag_we && !cfg_req && !swr_req && !stk_req && !bor_req && !pin_req)
      |=> (cause_flags == ($past(cause_flags) | 7'b0001000))); // R9
  AST_WRITE_NO_RESET: assert property (@(posedge clk) disable iff (!armed || por_req)
    (flag_we && !acc && !sys_rst) |=> (!sys_rst && cause_flags == $past(flag_wdata))); // R10
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!armed || por_req)
    (flag_we && stk_req) |=> cause_flags[6]); // R11
endmodule

bind rst_ctrl rst_ctrl_chk u_chk (.*);

// File: tb/rst_ctrl_bench.sv
module rst_ctrl_bench;
  localparam int PWT = 4, OSTC = 8, TP = 3;

  logic clk = 1'b0;
  logic por_req = 1'b1, bor_req = 0, bor_en = 1, pin_req = 0, pin_en = 1;
  logic wdt_req = 0, cfg_req = 0, swr_req = 0, stk_req = 0, tb_tick = 0;
  logic skip_pwrt = 0, skip_ost = 0, flag_we = 0;
  logic [6:0] flag_wdata = '0;
  logic sys_rst;
  logic [6:0] cause_flags;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  rst_ctrl #(.PW_TICKS(PWT), .OST_CYC(OSTC)) u_rst_ctrl (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int c, input logic v);
    case (c)
      0: por_req = v; 1: bor_req = v; 2: pin_req = v; 3: wdt_req = v;
      4: cfg_req = v; 5: swr_req = v; default: stk_req = v;
    endcase
  endtask

  task automatic measure(output int n);
    int k = 0;
    bit done = 0;
    while (!done && k < 500) begin
      k++;
      tb_tick = (k % TP == 0);
      @(negedge clk);
      if (!sys_rst) done = 1;
    end
    tb_tick = 0;
    n = k;
  endtask

  function automatic int exp_n(input int c, input bit sp, input bit so);
    int base = PWT * TP;
    if ((c == 0 || c == 1) && !sp) return so ? base : base + OSTC;
    return so ? 1 : OSTC;
  endfunction

  task automatic wr(input logic [6:0] p);
    flag_we = 1; flag_wdata = p;
    @(negedge clk);
    flag_we = 0;
    chk("R10 write value", cause_flags, p);
    chk("R10 write no reset", sys_rst, 0);
  endtask

  initial begin
    int n;
    logic [6:0] pat;
    repeat (3) @(negedge clk);
    por_req = 0;
    chk("R1 por holds reset", sys_rst, 1);
    measure(n);
    chk("R4 initial release", n, PWT * TP + OSTC);
    chk("R8 por defaults", cause_flags, 7'b0000001);

    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 7; c++) begin
        skip_pwrt = s[0]; skip_ost = s[1];
        pat = 7'((c * 37 + s * 11) & 7'h7E);
        wr(pat);
        drive(c, 1);
        @(negedge clk);
        drive(c, 0);
        chk($sformatf("R1 cause %0d asserts", c), sys_rst, 1);
        measure(n);
        chk($sformatf("R4 R5 R6 release cause %0d skip %0d", c, s), n, exp_n(c, s[0], s[1]));
        if (c == 0) chk("R8 por flags", cause_flags, 7'b0000001);
        else chk($sformatf("R9 cause %0d flags", c), cause_flags, pat | 7'(1 << c));
      end
    end
    skip_pwrt = 0; skip_ost = 0;

    wr(7'b0100100);
    pin_en = 0; pin_req = 1;
    @(negedge clk);
    pin_req = 0;
    chk("R2 pin gated reset", sys_rst, 0);
    chk("R2 pin gated flags", cause_flags, 7'b0100100);
    bor_en = 0; bor_req = 1;
    @(negedge clk);
    bor_req = 0;
    chk("R3 bor gated reset", sys_rst, 0);
    chk("R3 bor gated flags", cause_flags, 7'b0100100);
    pin_en = 1; bor_en = 1;

    wdt_req = 1;
    @(negedge clk);
    wdt_req = 0;
    repeat (5) @(negedge clk);
    chk("R7 still in reset", sys_rst, 1);
    wdt_req = 1;
    @(negedge clk);
    wdt_req = 0;
    measure(n);
    chk("R7 restart timing", n, OSTC);

    flag_we = 1; flag_wdata = 7'b0000000; stk_req = 1;
    @(negedge clk);
    flag_we = 0; stk_req = 0;
    chk("R11 event beats write", cause_flags, 7'b1000000);
    measure(n);
    chk("R5 release after collision", n, OSTC);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule